// File: doc/BRIEF.md
# Rename History Log with Commit-Driven Release

This block keeps an in-order log of destination-register renames for a single thread. Each rename writes one record into the log. A record holds the instruction's sequence number, the architectural register, the physical register just allocated to it, and the physical register that the architectural register was mapped to before. New records enter at the young end of a circular store.

When the pipeline commits up to a sequence number, the block drains the log from the oldest end. It retires one record per clock for as long as the oldest record's sequence number is at or below the committed value. For each retired record it presents the displaced (prior) physical register on a single free-list return port, with a valid strobe. A running counter records how many mappings have been retired. While a drain is in progress, `busy` is high. `full` tells the renaming logic to hold back further renames.

Top module: `rename_history`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `busy`, `rel_valid` and `retired_total` are all 0.
- R2: A push (`push_valid` high while `full` is low) appends one record at the young end. `full` goes high once DEPTH records are held.
- R3: A push offered while `full` is high is dropped. The log keeps exactly DEPTH records, and the dropped record is never released.
- R4: A commit request made while the log is empty releases nothing. `busy` is high for one cycle and then falls.
- R5: If the oldest record's sequence number is greater than the committed number, no record is released and the log is unchanged.
- R6: A commit releases the oldest records in push order, one per clock, starting in the cycle after the request. It stops at the first record younger than the committed number, or when the log runs empty.
- R7: While `rel_valid` is high, `rel_old_preg` carries the released record's prior physical register. `rel_seq`, `rel_areg` and `rel_new_preg` carry the same record's other fields.
- R8: `retired_total` rises by exactly one for each cycle in which `rel_valid` is high.
- R9: `busy` rises in the cycle after a commit request and falls once no eligible record remains. A new commit request while `busy` is high replaces the committed number used for the rest of the drain.
- R10: Sequence numbers compare as 16-bit unsigned values with no wraparound, and a record whose sequence number equals the committed number is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Record a rename this cycle |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_old_preg | input | PREG_W | Physical register displaced by the rename |
| commit_valid | input | 1 | Commit request strobe |
| commit_seq | input | SEQ_W | Highest committed sequence number |
| rel_valid | output | 1 | A record is released this cycle |
| rel_old_preg | output | PREG_W | Register returned to the free list |
| rel_seq | output | SEQ_W | Sequence number of the released record |
| rel_areg | output | AREG_W | Architectural register of the released record |
| rel_new_preg | output | PREG_W | New physical register of the released record |
| busy | output | 1 | Commit drain in progress |
| full | output | 1 | All DEPTH slots are occupied |
| empty | output | 1 | No records held |
| retired_total | output | CNT_W | Count of released mappings |

## Verification
The bench builds a log that holds two records with the same sequence number. It then commits at values below the oldest record, between records, and exactly equal to a record. A design that compares with a strict less-than would leave the equal record stranded. A design that does not stop at the first younger record would free registers still in use. Tests also cover a commit on an empty log, a push offered while full, and a second commit arriving mid-drain. Faults in those tests show up as a spurious release, a stray ninth release of a dropped record, or a drain that stops at the stale target. Every released register is compared against the prior register pushed in that order. Swapping in the new register, or draining from the young end, therefore fails immediately.

// File: rtl/rename_history.sv
module rename_history #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new_preg,
  input  logic [PREG_W-1:0] push_old_preg,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              rel_valid,
  output logic [PREG_W-1:0] rel_old_preg,
  output logic [SEQ_W-1:0]  rel_seq,
  output logic [AREG_W-1:0] rel_areg,
  output logic [PREG_W-1:0] rel_new_preg,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  retired_total
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] CAP  = OCC_W'(DEPTH);

  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [PREG_W-1:0] newp_q [DEPTH];
  logic [PREG_W-1:0] oldp_q [DEPTH];

  logic [PTR_W-1:0] head, tail;
  logic [OCC_W-1:0] occ;
  logic [SEQ_W-1:0] target;
  logic             active;
  logic             push_ok, retire;

  assign empty   = (occ == '0);
  assign full    = (occ == CAP);
  assign push_ok = push_valid && !full;
  assign retire  = active && !empty && (seq_q[head] <= target);

  assign rel_valid    = retire;
  assign rel_old_preg = oldp_q[head];
  assign rel_seq      = seq_q[head];
  assign rel_areg     = areg_q[head];
  assign rel_new_preg = newp_q[head];
  assign busy         = active;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) begin
      seq_q[tail]  <= push_seq;
      areg_q[tail] <= push_areg;
      newp_q[tail] <= push_new_preg;
      oldp_q[tail] <= push_old_preg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push_ok) tail <= step(tail);
      if (retire)  head <= step(head);
      case ({push_ok, retire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      target <= '0;
    end else if (commit_valid) begin
      active <= 1'b1;
      target <= commit_seq;
    end else if (active && !retire) begin
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) retired_total <= '0;
    else        retired_total <= retired_total + CNT_W'(retire);
  end

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !retire) |=> full);

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rel_valid);

  p_release_in_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> busy);

  p_commit_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> busy);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> (retired_total == $past(retired_total) + 1'b1));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_valid |=> $stable(retired_total));

  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !push_valid && !empty) |=> (occ == $past(occ) - 1'b1));

endmodule

// File: tb/rename_history_test.sv
`timescale 1ns/100ps
module rename_history_test;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16, AREG_W = 5, PREG_W = 7, CNT_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, commit_valid = 1'b0;
  logic [SEQ_W-1:0]  push_seq = '0, commit_seq = '0;
  logic [AREG_W-1:0] push_areg = '0;
  logic [PREG_W-1:0] push_new_preg = '0, push_old_preg = '0;
  logic rel_valid, busy, full, empty;
  logic [PREG_W-1:0] rel_old_preg, rel_new_preg;
  logic [SEQ_W-1:0]  rel_seq;
  logic [AREG_W-1:0] rel_areg;
  logic [CNT_W-1:0]  retired_total;

  rename_history #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
                   .PREG_W(PREG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
    .push_new_preg(push_new_preg), .push_old_preg(push_old_preg),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .rel_valid(rel_valid), .rel_old_preg(rel_old_preg), .rel_seq(rel_seq),
    .rel_areg(rel_areg), .rel_new_preg(rel_new_preg),
    .busy(busy), .full(full), .empty(empty), .retired_total(retired_total));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench-side model of pushed records
  int m_seq[64], m_areg[64], m_new[64], m_old[64];
  int m_wr = 0, m_rd = 0;
  int log_n = 0, log_bad = 0;

  always @(negedge clk) begin
    if (rst_n && rel_valid) begin
      checks++;
      if (m_rd >= m_wr || int'(rel_old_preg) != m_old[m_rd] ||
          int'(rel_seq) != m_seq[m_rd] || int'(rel_areg) != m_areg[m_rd] ||
          int'(rel_new_preg) != m_new[m_rd]) begin
        fails++; log_bad++;
        $display("FAIL R7: released preg %0d seq %0d, expected preg %0d seq %0d",
                 rel_old_preg, rel_seq,
                 (m_rd < m_wr) ? m_old[m_rd] : -1, (m_rd < m_wr) ? m_seq[m_rd] : -1);
      end
      m_rd++; log_n++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int s, input int a, input int np, input int op, input bit model);
    @(negedge clk);
    push_valid = 1'b1; push_seq = SEQ_W'(s); push_areg = AREG_W'(a);
    push_new_preg = PREG_W'(np); push_old_preg = PREG_W'(op);
    if (model) begin
      m_seq[m_wr] = s; m_areg[m_wr] = a; m_new[m_wr] = np; m_old[m_wr] = op; m_wr++;
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic drain_wait();
    int guard = 0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic commit(input int s);
    log_n = 0;
    @(negedge clk);
    commit_valid = 1'b1; commit_seq = SEQ_W'(s);
    @(negedge clk);
    commit_valid = 1'b0;
    drain_wait();
  endtask

  localparam int NV = 7;
  localparam int VEC_SEQ [NV] = '{5, 11, 12, 14, 26, 27, 30};
  localparam int VEC_N   [NV] = '{0, 1, 2, 0, 2, 1, 0};
  localparam int PUSH_SEQ[6]  = '{10, 12, 12, 15, 20, 27};

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(full == 1'b0 && busy == 1'b0, "R1 full/busy", {full, busy}, 0);
    check(rel_valid == 1'b0, "R1 rel_valid", rel_valid, 0);
    check(retired_total == 0, "R1 retired_total", retired_total, 0);

    // R4 commit on empty log
    log_n = 0;
    @(negedge clk); commit_valid = 1'b1; commit_seq = 16'd100;
    @(negedge clk); commit_valid = 1'b0;
    check(busy == 1'b1 && rel_valid == 1'b0, "R4 busy, no release", {busy, rel_valid}, 2);
    @(negedge clk);
    check(busy == 1'b0, "R4 busy falls", busy, 0);
    check(log_n == 0, "R4 released", log_n, 0);

    // R2 fill with vector-table records (seq, areg, new, old)
    for (int i = 0; i < 6; i++) push(PUSH_SEQ[i], i + 1, i + 32, PUSH_SEQ[i] + 64, 1'b1);
    check(empty == 1'b0 && full == 1'b0, "R2 partial occupancy", {empty, full}, 0);

    // R5 R6 R10 vector table
    for (int v = 0; v < NV; v++) begin
      commit(VEC_SEQ[v]);
      check(log_n == VEC_N[v], $sformatf("R6 R10 releases at commit %0d", VEC_SEQ[v]),
            log_n, VEC_N[v]);
    end
    check(empty == 1'b1, "R6 drained empty", empty, 1);
    check(retired_total == 6, "R8 count after table", retired_total, 6);

    // R5 explicit: older-than-oldest commit leaves log intact
    push(500, 3, 40, 9, 1'b1);
    commit(499);
    check(log_n == 0 && empty == 1'b0, "R5 nothing released", log_n, 0);
    commit(500);
    check(log_n == 1 && empty == 1'b1, "R10 equal released", log_n, 1);

    // R2 R3 full and dropped push
    for (int i = 0; i < DEPTH; i++) push(1000 + i, i, i + 16, i + 1, 1'b1);
    check(full == 1'b1, "R2 full at DEPTH", full, 1);
    push(600, 7, 77, 99, 1'b0);
    check(full == 1'b1, "R3 still full", full, 1);
    commit(2000);
    check(log_n == DEPTH, "R3 dropped record not released", log_n, DEPTH);
    check(empty == 1'b1, "R3 empty after drain", empty, 1);

    // R9 second commit mid-drain widens target
    for (int i = 0; i < 4; i++) push(3000 + i, i, i + 50, i + 20, 1'b1);
    log_n = 0;
    @(negedge clk); commit_valid = 1'b1; commit_seq = 16'd3000;
    @(negedge clk); commit_seq = 16'd3003;
    check(busy == 1'b1, "R9 busy after commit", busy, 1);
    @(negedge clk); commit_valid = 1'b0;
    drain_wait();
    check(log_n == 4, "R9 replaced target drains all", log_n, 4);
    check(busy == 1'b0, "R9 busy falls", busy, 0);

    // R8 total count, R7 field mismatches
    check(retired_total == 6 + 1 + DEPTH + 4, "R8 total", retired_total, 6 + 1 + DEPTH + 4);
    check(log_bad == 0, "R7 field mismatches", log_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule